// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register transactions from a host to an Ethernet PHY over the two-wire management bus. The host selects read or write, places a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data on its inputs, and then pulses `start`. The block generates MDC from the system clock through a fixed divider and serializes the whole frame on MDIO. It controls a tri-state output enable so that MDIO is released during the read turnaround, during read data and while idle.

Each frame opens with 32 preamble clocks and then carries the start, opcode and address fields. For a write, the block drives the turnaround and the data, then adds one trailing clock with the line released. For a read, the block samples the second turnaround bit. If the PHY does not pull that bit low, the block sends a recovery burst of 32 released clocks and flags an error. Otherwise it shifts in 16 data bits and adds two trailing clocks. When the frame ends, `done` pulses for one clock.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 MDC cycles in which MDIO is driven (oe=1) at 1.
- R2: The next 14 bits are driven in this order: 0, 1, the opcode (1,0 for read, 0,1 for write), the PHY address MSB first, then the register address MSB first.
- R3: MDC is low for DIV system clocks and then high for DIV system clocks. Each frame bit is set up at the start of the low phase, and mdio_o and mdio_oe hold steady while MDC is high.
- R4: A write drives the turnaround as 1 then 0 and then 16 data bits MSB first. It ends with one cycle in which MDIO is released, so a write frame has 65 MDC cycles.
- R5: A read releases MDIO from the turnaround onward. It samples the second turnaround bit and then 16 data bits MSB first when MDC rises, and it ends after two trailing cycles, so a good read frame has 66 MDC cycles. On a good read, rdata takes the sampled word and err is 0.
- R6: If the sampled read turnaround bit is 1, the block gives 32 further released MDC cycles, for 80 in total. It then sets err to 1 and leaves rdata at its previous value.
- R7: While idle, mdio_oe is 0 and MDC is 0. Within a frame, mdio_oe is 1 only during the preamble, start, opcode, address, write turnaround and write data cycles.
- R8: A start pulse that arrives while busy is high is ignored: the frame in progress is not altered, and only one done pulse results.
- R9: done is high for exactly one system clock as busy falls. err keeps its value until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| rd | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Data from the last good read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| err | output | 1 | Read turnaround was not driven low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench issues random reads and writes with random addresses, write data and PHY response words. The PHY model answers each read with either a low or a high turnaround bit, so good reads and the recovery path are both exercised. Directed cases cover all-zero and all-one fields, which would expose a bit-order or opcode swap that random values might hide. They also cover back-to-back errors followed by a good read, which shows that err is cleared and that rdata is kept on failure. A start pulse injected in the middle of a frame shows that a second request cannot restart or corrupt the frame.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);
  localparam logic [6:0] S_HDR  = 7'd32;
  localparam logic [6:0] S_TA1  = 7'd46;
  localparam logic [6:0] S_TA2  = 7'd47;
  localparam logic [6:0] S_D0   = 7'd48;
  localparam logic [6:0] S_DL   = 7'd63;
  localparam logic [6:0] S_WEND = 7'd64;
  localparam logic [6:0] S_REND = 7'd65;
  localparam logic [6:0] S_BEND = 7'd79;

  logic [CW-1:0] cnt;
  logic [6:0]    slot;
  logic          rd_q, bad;
  logic [4:0]    pa_q, ra_q;
  logic [15:0]   wd_q, sh;
  logic [13:0]   hdr;
  logic          drv, bitv;
  logic [6:0]    last;
  logic          tick;

  assign hdr  = {2'b01, rd_q, ~rd_q, pa_q, ra_q};
  assign tick = (cnt == CNT_TOP);
  assign last = rd_q ? (bad ? S_BEND : S_REND) : S_WEND;

  always_comb begin
    drv  = 1'b0;
    bitv = 1'b1;
    if (slot < S_HDR) begin
      drv = 1'b1;
    end else if (slot < S_TA1) begin
      drv  = 1'b1;
      bitv = hdr[4'(7'd45 - slot)];
    end else if (!rd_q) begin
      if (slot == S_TA1) begin
        drv = 1'b1;
      end else if (slot == S_TA2) begin
        drv  = 1'b1;
        bitv = 1'b0;
      end else if (slot <= S_DL) begin
        drv  = 1'b1;
        bitv = wd_q[4'(S_DL - slot)];
      end
    end
  end

  assign mdio_oe = busy & drv;
  assign mdio_o  = busy ? bitv : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      mdc   <= 1'b0;
      cnt   <= '0;
      slot  <= '0;
      rd_q  <= 1'b0;
      bad   <= 1'b0;
      pa_q  <= '0;
      ra_q  <= '0;
      wd_q  <= '0;
      sh    <= '0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          err  <= 1'b0;
          bad  <= 1'b0;
          mdc  <= 1'b0;
          cnt  <= '0;
          slot <= '0;
          rd_q <= rd;
          pa_q <= phy_addr;
          ra_q <= reg_addr;
          wd_q <= wdata;
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (rd_q && slot == S_TA2) bad <= mdio_i;
          if (rd_q && slot >= S_D0 && slot <= S_DL && !bad) sh <= {sh[14:0], mdio_i};
        end else if (slot == last) begin
          busy <= 1'b0;
          done <= 1'b1;
          err  <= rd_q & bad;
          if (rd_q && !bad) rdata <= sh;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [6:0] slot,
  input logic       rd_q
);
  assert_preamble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot < 7'd32) |-> (mdio_oe && mdio_o));

  assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && slot >= 7'd46) |-> !mdio_oe);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (slot >= $past(slot)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .slot(slot), .rd_q(rd_q)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy, done, err, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int vecs = 0, fails = 0, cyc = 0;

  mdio_master #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd(rd), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
    .err(err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  logic cap_oe [0:127];
  logic cap_v  [0:127];
  int nslot = 0;
  logic [15:0] phy_word = '0;
  logic phy_ta = 1'b0;

  always @(posedge mdc) begin
    if (nslot < 128) begin
      cap_oe[nslot] = mdio_oe;
      cap_v[nslot]  = mdio_o;
    end
    nslot++;
  end

  always @(negedge mdc) begin
    if (nslot == 47) mdio_i = phy_ta;
    else if (nslot >= 48 && nslot <= 63) mdio_i = phy_word[63 - nslot];
    else mdio_i = 1'b1;
  end

  int run = 0, halfbad = 0;
  logic have = 1'b0, prev_mdc = 1'b0;
  always @(negedge clk) begin
    run++;
    if (mdc !== prev_mdc) begin
      if (have && run != DIV) halfbad++;
      have = 1'b1;
      run = 0;
    end
    prev_mdc = mdc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_hdr(input logic r, input logic [4:0] pa, input logic [4:0] ra);
    return {2'b01, (r ? 2'b10 : 2'b01), pa, ra};
  endfunction

  logic [15:0] last_rdata = '0;

  task automatic txn(input logic r, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] wd, input logic [15:0] pw, input logic ta,
                     input bit inject);
    int n_done, waitc, exp_n;
    bit ok;
    logic [13:0] h;
    phy_word = pw;
    phy_ta = ta;
    @(negedge clk);
    nslot = 0;
    have = 1'b0;
    halfbad = 0;
    mdio_i = 1'b1;
    rd = r; phy_addr = pa; reg_addr = ra; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && err === 1'b0, "R9 err cleared on start", {busy, err}, 2);
    n_done = 0;
    waitc = 0;
    while (!done && waitc < 2000) begin
      @(negedge clk);
      waitc++;
      if (inject && waitc == 200) begin
        rd = ~r; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd; start = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    if (done) n_done++;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 done single cycle", {done, busy}, 0);
    repeat (3 * DIV) begin
      @(negedge clk);
      if (done) n_done++;
    end
    chk(n_done == 1, "R8 single done", n_done, 1);
    exp_n = r ? (ta ? 80 : 66) : 65;
    chk(nslot == exp_n, r ? (ta ? "R6 frame length" : "R5 frame length") : "R4 frame length", nslot, exp_n);
    ok = 1;
    for (int i = 0; i < 32; i++) if (cap_oe[i] !== 1'b1 || cap_v[i] !== 1'b1) ok = 0;
    chk(ok, "R1 preamble", 0, 1);
    h = exp_hdr(r, pa, ra);
    ok = 1;
    for (int i = 0; i < 14; i++) if (cap_oe[32+i] !== 1'b1 || cap_v[32+i] !== h[13-i]) ok = 0;
    chk(ok, "R2 header", 0, 1);
    chk(halfbad == 0, "R3 MDC half period", halfbad, 0);
    if (!r) begin
      ok = (cap_oe[46] === 1'b1 && cap_v[46] === 1'b1 && cap_oe[47] === 1'b1 && cap_v[47] === 1'b0);
      for (int i = 0; i < 16; i++) if (cap_oe[48+i] !== 1'b1 || cap_v[48+i] !== wd[15-i]) ok = 0;
      if (cap_oe[64] !== 1'b0) ok = 0;
      chk(ok, "R4 write turnaround/data/release", 0, 1);
      chk(err === 1'b0 && rdata === last_rdata, "R4 write leaves rdata", rdata, last_rdata);
    end else begin
      ok = 1;
      for (int i = 46; i < exp_n && i < 128; i++) if (cap_oe[i] !== 1'b0) ok = 0;
      chk(ok, "R7 read slots released", 0, 1);
      if (ta) begin
        chk(err === 1'b1, "R6 err set", err, 1);
        chk(rdata === last_rdata, "R6 rdata kept", rdata, last_rdata);
      end else begin
        chk(err === 1'b0, "R5 err clear", err, 0);
        chk(rdata === pw, "R5 rdata", rdata, pw);
        last_rdata = pw;
      end
    end
    chk(mdio_oe === 1'b0 && mdc === 1'b0, "R7 idle quiet", {mdio_oe, mdc}, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd77123);
    repeat (4) @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0 && mdio_oe === 0 && mdc === 0 && rdata === 0,
        "R7 reset state", {busy, done, err, mdio_oe, mdc}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mdio_oe === 0 && mdc === 0, "R7 idle after reset", {mdio_oe, mdc}, 0);

    txn(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0, 0);
    txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1'b0, 0);
    txn(1'b1, 5'h15, 5'h0A, 16'h0, 16'hA5C3, 1'b0, 0);
    txn(1'b1, 5'h03, 5'h11, 16'h0, 16'h1234, 1'b1, 0);
    repeat (20) @(negedge clk);
    chk(err === 1'b1, "R9 err held", err, 1);
    txn(1'b1, 5'h07, 5'h02, 16'h0, 16'hFFFF, 1'b1, 0);
    txn(1'b1, 5'h1F, 5'h00, 16'h0, 16'h8001, 1'b0, 0);
    txn(1'b0, 5'h09, 5'h16, 16'hC00F, 16'h0, 1'b0, 1);
    txn(1'b1, 5'h12, 5'h05, 16'h0, 16'h5AA5, 1'b0, 1);

    for (int k = 0; k < 24; k++) begin
      logic r, ta;
      r = 1'($urandom);
      ta = (($urandom % 4) == 0);
      txn(r, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), ta, ($urandom % 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule